// File: doc/BRIEF.md
# Timestamped Multi-Link Pixel Packet Merger

This block gathers pixel packets arriving on several parallel receive links, all already in the merger clock domain. Every packet that is accepted is joined to the current value of a free-running coarse time counter. The combined word is parked in a small FIFO that belongs to that link. A round-robin arbiter then moves the parked words, one per clock, into a single deep output FIFO. Downstream logic reads that FIFO through a show-ahead interface with data, empty and read-request. An almost-full flag lets the downstream side throttle the source.

A packet is nominally 48 bits wide. It carries a 4-bit control header, a 16-bit pixel address, an 18-bit arrival time and a 10-bit time-over-threshold value. The merger does not interpret these fields. It keeps the packet intact in the low bits of the stored word and places the timestamp above it. A link whose FIFO is full loses the new packet, and a sticky overflow bit records the loss.

Top module: `pxm_merger`

## Requirements
- R1: After reset, `out_empty` is 1, `out_almost_full` is 0, every `link_overflow` bit is 0 and every link FIFO is empty. A second reset clears the overflow bits again.
- R2: Each stored word is `{timestamp, packet}`. The timestamp sits in the upper TS_W bits and the unchanged packet sits in the lower PKT_W bits.
- R3: The timestamp counter reads 0 in the first cycle after reset is released and adds one on every clock, wrapping modulo 2^TS_W. A packet receives the value the counter holds in the cycle in which the packet is accepted.
- R4: A link accepts a packet in any cycle where its valid bit is 1 and its FIFO was not full at the start of that cycle. Packets from one link leave in the order in which they arrived.
- R5: A packet offered to a full link FIFO is discarded and never appears at the output. It sets that link's overflow bit, which stays at 1 until reset.
- R6: The arbiter searches the links in rising index order, wrapping around. The search starts at the link after the one served last and skips links whose FIFO is empty. The first search after reset starts at link 0.
- R7: At most one word moves into the output FIFO per clock, and only while that FIFO is not full. Words that cannot move stay in their link FIFOs.
- R8: Whenever `out_empty` is 0, `out_data` holds the oldest word, and a clock with `out_rd_req` at 1 removes it. A read request while `out_empty` is 1 has no effect.
- R9: `out_almost_full` is 1 exactly when the output FIFO holds at least OUT_AFULL words.
- R10: With no contention and an empty output FIFO, a packet accepted at one rising edge clears `out_empty` after the following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Merger clock |
| rst | input | 1 | Synchronous active-high reset |
| link_valid | input | NUM_LINKS | Per-link packet strobe |
| link_data | input | NUM_LINKS*PKT_W | Per-link packets; link i occupies bits [i*PKT_W +: PKT_W] |
| link_overflow | output | NUM_LINKS | Sticky per-link drop flags |
| out_rd_req | input | 1 | Pop the head word of the output FIFO |
| out_data | output | PKT_W+TS_W | Head word of the output FIFO |
| out_empty | output | 1 | Output FIFO holds no word |
| out_almost_full | output | 1 | Output FIFO level is at or above OUT_AFULL |

## Verification
The bench builds the merger with 3 links, 16-bit packets, a 6-bit timestamp, link FIFOs 4 deep and an output FIFO 8 deep with its threshold at 6. The short timestamp wraps within a few dozen cycles, so the wrap from 63 to 0 can be checked directly. The shallow FIFOs fill within a handful of cycles, which makes the output-full stall, the partial drain of the link FIFOs and a link overflow all reachable in one short sequence. With only three links, every round-robin order (the starting point after reset, a rotation that skips a link, and service resuming after a stall) can be written out by hand and compared word by word, timestamps included.

// File: rtl/pxm_pkg.sv
package pxm_pkg;

  // Address width for a storage of the given depth (never below one bit).
  function automatic int unsigned ptr_w(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Counter width able to hold the values 0..depth.
  function automatic int unsigned lvl_w(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/pxm_ts_counter.sv
module pxm_ts_counter #(
  parameter int unsigned TS_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ts == TS_W'($past(ts) + 1'b1)); // R3

endmodule

// File: rtl/pxm_fifo.sv
module pxm_fifo #(
  parameter int unsigned W     = 68,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AFULL = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         almost_full
);

  localparam int unsigned AW = pxm_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = pxm_pkg::lvl_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level, level_nxt;
  logic          do_wr, do_rd;

  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage has no reset so it can map onto RAM resources.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_comb begin
    level_nxt = level;
    if (do_wr && !do_rd) level_nxt = level + 1'b1;
    if (do_rd && !do_wr) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      level       <= '0;
      empty       <= 1'b1;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      level       <= level_nxt;
      empty       <= (level_nxt == '0);
      full        <= (level_nxt == CW'(DEPTH));
      almost_full <= (level_nxt >= CW'(AFULL));
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R8
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full); // R7

endmodule

// File: rtl/pxm_rr_arb.sv
module pxm_rr_arb #(
  parameter int unsigned N = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N-1:0]                    req,
  input  logic                            en,
  output logic [N-1:0]                    grant,
  output logic [pxm_pkg::ptr_w(N)-1:0]    gnt_idx,
  output logic                            gnt_valid
);

  localparam int unsigned IW = pxm_pkg::ptr_w(N);

  logic [IW-1:0] last;

  // Rotating search starting one past the last served link.
  always_comb begin
    grant     = '0;
    gnt_idx   = '0;
    gnt_valid = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int unsigned c;
      c = (int'(last) + k) % N;
      if (!gnt_valid && en && req[c]) begin
        gnt_valid = 1'b1;
        grant[c]  = 1'b1;
        gnt_idx   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            last <= IW'(N - 1);
    else if (gnt_valid) last <= gnt_idx;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0); // R6
  AST_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !en |-> grant == '0); // R7

endmodule

// File: rtl/pxm_merger.sv
module pxm_merger #(
  parameter int unsigned NUM_LINKS  = 8,
  parameter int unsigned PKT_W      = 48,
  parameter int unsigned TS_W       = 20,
  parameter int unsigned LINK_DEPTH = 16,
  parameter int unsigned OUT_DEPTH  = 1024,
  parameter int unsigned OUT_AFULL  = 960
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINKS-1:0]       link_valid,
  input  logic [NUM_LINKS*PKT_W-1:0] link_data,
  output logic [NUM_LINKS-1:0]       link_overflow,
  input  logic                       out_rd_req,
  output logic [PKT_W+TS_W-1:0]      out_data,
  output logic                       out_empty,
  output logic                       out_almost_full
);

  localparam int unsigned WORD_W = PKT_W + TS_W;
  localparam int unsigned IW     = pxm_pkg::ptr_w(NUM_LINKS);

  logic [TS_W-1:0]      ts_now;
  logic [NUM_LINKS-1:0] lq_empty, lq_full, lq_afull;
  logic [WORD_W-1:0]    lq_rdata [NUM_LINKS];
  logic [NUM_LINKS-1:0] grant;
  logic [IW-1:0]        gnt_idx;
  logic                 gnt_valid;
  logic                 oq_full;
  logic [WORD_W-1:0]    oq_wdata;

  pxm_ts_counter #(.TS_W(TS_W)) ts_i (
    .clk (clk),
    .rst (rst),
    .ts  (ts_now)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic lq_wr;
    assign lq_wr = link_valid[i] & ~lq_full[i];

    pxm_fifo #(.W(WORD_W), .DEPTH(LINK_DEPTH), .AFULL(LINK_DEPTH)) lq_i (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (lq_wr),
      .wr_data     ({ts_now, link_data[i*PKT_W +: PKT_W]}),
      .rd_en       (grant[i]),
      .rd_data     (lq_rdata[i]),
      .empty       (lq_empty[i]),
      .full        (lq_full[i]),
      .almost_full (lq_afull[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                             link_overflow[i] <= 1'b0;
      else if (link_valid[i] & lq_full[i]) link_overflow[i] <= 1'b1;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      link_overflow[i] |=> link_overflow[i]); // R5
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (link_valid[i] && lq_full[i]) |=> link_overflow[i]); // R5
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> !lq_empty[i]); // R6
    AST_LINK_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
      lq_full[i] |-> lq_afull[i]); // R4
  end

  pxm_rr_arb #(.N(NUM_LINKS)) arb_i (
    .clk       (clk),
    .rst       (rst),
    .req       (~lq_empty),
    .en        (~oq_full),
    .grant     (grant),
    .gnt_idx   (gnt_idx),
    .gnt_valid (gnt_valid)
  );

  assign oq_wdata = lq_rdata[gnt_idx];

  pxm_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH), .AFULL(OUT_AFULL)) oq_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (gnt_valid),
    .wr_data     (oq_wdata),
    .rd_en       (out_rd_req),
    .rd_data     (out_data),
    .empty       (out_empty),
    .full        (oq_full),
    .almost_full (out_almost_full)
  );

  AST_NO_MOVE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> !oq_full); // R7
  AST_AFULL_BEFORE_FULL: assert property (@(posedge clk) disable iff (rst)
    oq_full |-> out_almost_full); // R9

endmodule

// File: tb/pxm_merger_tb.sv
module pxm_merger_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL  = 3;
  localparam int PW  = 16;
  localparam int TSW = 6;
  localparam int WW  = PW + TSW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NL-1:0]     link_valid = '0;
  logic [NL*PW-1:0]  link_data  = '0;
  logic [NL-1:0]     link_overflow;
  logic              out_rd_req = 1'b0;
  logic [WW-1:0]     out_data;
  logic              out_empty;
  logic              out_almost_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [TSW-1:0] tb_ts;
  int exp_ts [NL][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench's own time base, following R3.
  always_ff @(posedge clk) begin
    if (rst) tb_ts <= '0;
    else     tb_ts <= tb_ts + 1'b1;
  end

  pxm_merger #(
    .NUM_LINKS(NL), .PKT_W(PW), .TS_W(TSW),
    .LINK_DEPTH(4), .OUT_DEPTH(8), .OUT_AFULL(6)
  ) dut_i (
    .clk             (clk),
    .rst             (rst),
    .link_valid      (link_valid),
    .link_data       (link_data),
    .link_overflow   (link_overflow),
    .out_rd_req      (out_rd_req),
    .out_data        (out_data),
    .out_empty       (out_empty),
    .out_almost_full (out_almost_full)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pkt(int l, int r);
    return PW'((l << 12) | (r << 4) | 9);
  endfunction

  task automatic push(logic [NL-1:0] mask, int r);
    for (int l = 0; l < NL; l++) begin
      link_valid[l] = mask[l];
      link_data[l*PW +: PW] = pkt(l, r);
      if (mask[l]) exp_ts[l][r] = int'(tb_ts);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    link_valid = '0;
  endtask

  task automatic read_expect(int l, int r, string req);
    int w = 0;
    logic [WW-1:0] exp;
    while (out_empty && w < 30) begin
      @(negedge clk);
      w++;
    end
    exp = {TSW'(exp_ts[l][r]), pkt(l, r)};
    check(out_data == exp, req, "output word", longint'(out_data), longint'(exp));
    out_rd_req = 1'b1;
    @(negedge clk);
    out_rd_req = 1'b0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(out_empty == 1'b1, "R1", "out_empty", out_empty, 1);
    check(out_almost_full == 1'b0, "R1", "out_almost_full", out_almost_full, 0);
    check(link_overflow == '0, "R1", "link_overflow", link_overflow, 0);

    // R8: read request on empty FIFO is ignored
    out_rd_req = 1'b1;
    @(negedge clk);
    out_rd_req = 1'b0;
    check(out_empty == 1'b1, "R8", "empty after read on empty", out_empty, 1);

    // R10, R2, R3: single packet on link 1
    push(3'b010, 0);
    idle();
    check(out_empty == 1'b1, "R10", "empty one edge after accept", out_empty, 1);
    @(negedge clk);
    check(out_empty == 1'b0, "R10", "data two edges after accept", out_empty, 0);
    read_expect(1, 0, "R2");

    // R6, R9: round robin resumes after link 1
    push(3'b111, 0);
    push(3'b111, 1);
    idle();
    wait_cycles(8);
    check(out_almost_full == 1'b1, "R9", "almost full at 6 words", out_almost_full, 1);
    read_expect(2, 0, "R6");
    check(out_almost_full == 1'b0, "R9", "almost full at 5 words", out_almost_full, 0);
    read_expect(0, 0, "R6");
    read_expect(1, 0, "R6");
    read_expect(2, 1, "R6");
    read_expect(0, 1, "R4");
    read_expect(1, 1, "R4");
    check(out_empty == 1'b1, "R8", "empty after drain", out_empty, 1);

    // R6: empty link 1 skipped
    push(3'b101, 0);
    idle();
    wait_cycles(4);
    read_expect(2, 0, "R6");
    read_expect(0, 0, "R6");

    // R7, R5: output full stalls, link 0 overflows
    push(3'b111, 0);
    push(3'b111, 1);
    push(3'b111, 2);
    push(3'b111, 3);
    idle();
    wait_cycles(15);
    check(out_empty == 1'b0, "R7", "out holds words", out_empty, 0);
    check(out_almost_full == 1'b1, "R7", "out full level", out_almost_full, 1);
    check(link_overflow == '0, "R5", "no overflow yet", link_overflow, 0);
    push(3'b001, 4);
    push(3'b001, 5);
    push(3'b001, 6);
    idle();
    @(negedge clk);
    check(link_overflow == 3'b001, "R5", "link 0 overflow", link_overflow, 1);
    read_expect(1, 0, "R7");
    read_expect(2, 0, "R7");
    read_expect(0, 0, "R7");
    read_expect(1, 1, "R7");
    read_expect(2, 1, "R7");
    read_expect(0, 1, "R7");
    read_expect(1, 2, "R7");
    read_expect(2, 2, "R7");
    read_expect(0, 2, "R6");
    read_expect(1, 3, "R6");
    read_expect(2, 3, "R6");
    read_expect(0, 3, "R4");
    read_expect(0, 4, "R4");
    read_expect(0, 5, "R4");
    wait_cycles(10);
    check(out_empty == 1'b1, "R5", "dropped packet absent", out_empty, 1);
    check(link_overflow == 3'b001, "R5", "overflow sticky", link_overflow, 1);

    // R3: timestamp wraps from 63 to 0
    while (tb_ts != 6'd63) @(negedge clk);
    push(3'b100, 0);
    push(3'b100, 1);
    idle();
    exp_ts[2][0] = 63;
    exp_ts[2][1] = 0;
    read_expect(2, 0, "R3");
    read_expect(2, 1, "R3");

    // R1: second reset clears overflow
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(link_overflow == '0, "R1", "overflow cleared by reset", link_overflow, 0);
    check(out_empty == 1'b1, "R1", "empty after reset", out_empty, 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule